// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt causes for a small 8-bit controller core: two active-low external pins, two timer overflow pulses and one serial-port request formed from a receive flag and a transmit flag. It picks one cause and presents it to the core as a request with a 3-bit vector index. The core answers with a vector-acknowledge strobe when it enters the service routine and with a return strobe when it leaves it.

Each cause belongs to one of two priority levels, chosen by a software-written level register. A request from the high level wins over any low-level request. Inside one level a fixed order breaks ties. Two in-service bits, one per level, implement nesting: a running routine can be interrupted only by a request from a strictly higher level. Each external pin can be set to trigger on a falling edge, which latches a flag, or on a low level, which latches nothing.

Latched flags are cleared by hardware when the core acknowledges their vector, and a one-cycle clear pulse marks that event. A global enable and per-source enables mask requests before arbitration.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The level register maps bit 0 to external 0, bit 1 to timer 0, bit 2 to external 1, bit 3 to timer 1 and bit 4 to serial. A 1 puts the source in the high level. Bits 7..5 ignore writes and always read 0. Reset value is 0.
- R2: The control register holds these fields: bit 0 is the external 0 mode, bit 1 is the external 0 flag, bit 2 is the external 1 mode, bit 3 is the external 1 flag, bit 5 is the timer 0 flag and bit 7 is the timer 1 flag. Bits 4 and 6 read 0. Software writes load every held bit. Reset value is 0.
- R3: With its mode bit at 1, an external pin that is seen high and then low after synchronization sets its flag. The flag stays set after the pin returns high, and a pin that stays low does not set it again.
- R4: With its mode bit at 0, an external source requests while the synchronized pin is low. Its flag bit is not set in this mode.
- R5: A one-cycle overflow pulse on a timer input sets that timer's flag on the next clock edge.
- R6: The serial source requests while the receive flag or the transmit flag is high. The controller never clears either of them, and acknowledging the serial vector gives no clear pulse.
- R7: Among pending requests of the same level, the winner follows this order, from first to last: external 0 (vector 0), timer 0 (vector 1), external 1 (vector 2), timer 1 (vector 3), serial (vector 4).
- R8: Any high-level request wins over every low-level request, whatever their places in the tie order.
- R9: An acknowledge while a request is shown clears the latched flag of the vectored source and sets the in-service bit of its level. On the next cycle clr_pulse is high for one cycle, but only if a flag existed to be cleared.
- R10: While the high in-service bit is set, no request is shown. While only the low in-service bit is set, only high-level requests are shown.
- R11: A return strobe clears the high in-service bit if it is set. Otherwise it clears the low in-service bit.
- R12: With glob_en low, or with a source's src_en bit low, that source raises no request. Its latched flag is kept, and an acknowledge while nothing is shown changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_wr | input | 1 | Write strobe for the level register |
| lvl_wdata | input | 8 | Level register write data |
| lvl_rdata | output | 8 | Level register read data |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| src_en | input | 5 | Per-source enables, indexed by vector |
| glob_en | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Core acknowledges the shown vector |
| reti | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Vector index of the winning source |
| clr_pulse | output | 1 | One-cycle pulse after a latched flag is cleared by acknowledge |

## Verification
The bench builds the block with its default parameters: a two-stage pin synchronizer and an 8-bit register width. These defaults bring the reserved level bits into reach, and they give a fixed three-edge delay from a pin fall to a latched flag, which the edge and level scenarios count on. The scenarios cover ties across all five sources, a high-level source that sits last in the tie order, two-deep nesting unwound by two returns, edge and level pins held in both states, and acknowledges that arrive while requests are masked.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = $clog2(NSRC);

  typedef enum logic [VEC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  // lowest set index wins: this is the fixed tie order
  function automatic logic [VEC_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

  // whether acknowledging this vector clears a latched flag
  function automatic logic owns_flag(input logic [VEC_W-1:0] vec,
                                     input logic [1:0] edge_mode);
    case (vec)
      SRC_EXT0: owns_flag = edge_mode[0];
      SRC_EXT1: owns_flag = edge_mode[1];
      SRC_TMR0, SRC_TMR1: owns_flag = 1'b1;
      default:  owns_flag = 1'b0;
    endcase
  endfunction

  // one-hot clear mask over the four flagged sources (index = vector)
  function automatic logic [3:0] clear_mask(input logic take,
                                            input logic [VEC_W-1:0] vec);
    logic [3:0] m;
    m = '0;
    if (take && vec < VEC_W'(4)) m[vec[1:0]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_evt,
  output logic low_lvl
);
  // sh[STAGES-1] is the synchronized pin, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin_n};
  end

  assign fall_evt = sh[STAGES] & ~sh[STAGES-1];
  assign low_lvl  = ~sh[STAGES-1];
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       ext_fall,
  input  logic [1:0]       tmr_ovf,
  input  logic [3:0]       clr,
  output logic [1:0]       ext_mode,
  output logic [1:0]       ext_flag,
  output logic [1:0]       tmr_flag,
  output logic [REG_W-1:0] rdata
);
  localparam int B_M0 = 0;
  localparam int B_F0 = 1;
  localparam int B_M1 = 2;
  localparam int B_F1 = 3;
  localparam int B_T0 = 5;
  localparam int B_T1 = 7;

  logic [1:0] mode_q, ef_q, tf_q;
  logic [1:0] ef_base, tf_base;
  logic [1:0] ef_set;

  // edge flags latch only in falling-edge mode
  assign ef_set = ext_fall & mode_q;

  always_comb begin
    ef_base = wr ? {wdata[B_F1], wdata[B_F0]} : ef_q;
    tf_base = wr ? {wdata[B_T1], wdata[B_T0]} : tf_q;
    ef_base = ef_base & ~{clr[2], clr[0]};
    tf_base = tf_base & ~{clr[3], clr[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ef_q   <= '0;
      tf_q   <= '0;
    end else begin
      if (wr) mode_q <= {wdata[B_M1], wdata[B_M0]};
      ef_q <= ef_base | ef_set;
      tf_q <= tf_base | tmr_ovf;
    end
  end

  always_comb begin
    rdata       = '0;
    rdata[B_M0] = mode_q[0];
    rdata[B_F0] = ef_q[0];
    rdata[B_M1] = mode_q[1];
    rdata[B_F1] = ef_q[1];
    rdata[B_T0] = tf_q[0];
    rdata[B_T1] = tf_q[1];
  end

  assign ext_mode = mode_q;
  assign ext_flag = ef_q;
  assign tmr_flag = tf_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  prio,
  input  logic             in_hi,
  input  logic             in_lo,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic             win_hi
);
  logic [NSRC-1:0] hi_set, lo_set, cand;

  assign hi_set = pend & prio;
  assign lo_set = pend & ~prio;

  always_comb begin
    if (in_hi)      cand = '0;
    else if (in_lo) cand = hi_set;
    else            cand = (|hi_set) ? hi_set : lo_set;
  end

  assign req    = |cand;
  assign vec    = first_set(cand);
  assign win_hi = |(cand & prio);
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic in_hi,
  output logic in_lo
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = in_hi;
    lo_d = in_lo;
    if (ret) begin
      if (in_hi) hi_d = 1'b0;
      else       lo_d = 1'b0;
    end
    if (take) begin
      if (take_hi) hi_d = 1'b1;
      else         lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hi <= 1'b0;
      in_lo <= 1'b0;
    end else begin
      in_hi <= hi_d;
      in_lo <= lo_d;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_wr,
  input  logic [REG_W-1:0] lvl_wdata,
  output logic [REG_W-1:0] lvl_rdata,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glob_en,
  input  logic             vec_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             clr_pulse
);
  localparam int RSV_W = REG_W - NSRC;

  logic [1:0]       fall_evt, low_lvl;
  logic [1:0]       ext_mode, ext_flag, tmr_flag;
  logic [NSRC-1:0]  prio_q;
  logic [NSRC-1:0]  pend_raw, pend;
  logic             in_svc_hi, in_svc_lo;
  logic             win_hi;
  logic             ack_take;
  logic [3:0]       clr_mask;
  logic             clr_pulse_q;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pin
      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_n[g]),
        .fall_evt (fall_evt[g]),
        .low_lvl  (low_lvl[g])
      );
    end
  endgenerate

  // level register: reserved bits neither stored nor read back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prio_q <= '0;
    else if (lvl_wr) prio_q <= lvl_wdata[NSRC-1:0];
  end
  assign lvl_rdata = {{RSV_W{1'b0}}, prio_q};

  irq_ctl_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .ext_fall (fall_evt),
    .tmr_ovf  (tmr_ovf),
    .clr      (clr_mask),
    .ext_mode (ext_mode),
    .ext_flag (ext_flag),
    .tmr_flag (tmr_flag),
    .rdata    (ctl_rdata)
  );

  assign pend_raw[SRC_EXT0] = ext_mode[0] ? ext_flag[0] : low_lvl[0];
  assign pend_raw[SRC_TMR0] = tmr_flag[0];
  assign pend_raw[SRC_EXT1] = ext_mode[1] ? ext_flag[1] : low_lvl[1];
  assign pend_raw[SRC_TMR1] = tmr_flag[1];
  assign pend_raw[SRC_SER]  = ser_rx | ser_tx;
  assign pend = pend_raw & src_en & {NSRC{glob_en}};

  irq_pick u_pick (
    .pend   (pend),
    .prio   (prio_q),
    .in_hi  (in_svc_hi),
    .in_lo  (in_svc_lo),
    .req    (irq_req),
    .vec    (irq_vec),
    .win_hi (win_hi)
  );

  assign ack_take = vec_ack & irq_req;
  assign clr_mask = clear_mask(ack_take, irq_vec);

  irq_nest u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (ack_take),
    .take_hi (win_hi),
    .ret     (reti),
    .in_hi   (in_svc_hi),
    .in_lo   (in_svc_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_pulse_q <= 1'b0;
    else        clr_pulse_q <= ack_take & owns_flag(irq_vec, ext_mode);
  end
  assign clr_pulse = clr_pulse_q;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glob_en,
  input logic       irq_req,
  input logic [2:0] irq_vec,
  input logic       vec_ack,
  input logic       reti,
  input logic       ctl_wr,
  input logic [1:0] tmr_ovf,
  input logic [7:0] lvl_rdata,
  input logic [7:0] ctl_rdata,
  input logic       in_svc_hi,
  input logic       in_svc_lo,
  input logic       clr_pulse
);
  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_rdata[7:5] == 3'b000);

  p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec <= 3'd4);

  p_hi_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_hi |-> !irq_req);

  p_lo_admits_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_lo && irq_req) |-> lvl_rdata[irq_vec]);

  p_global_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req);

  p_tmr0_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq_req && irq_vec == 3'd1 && !tmr_ovf[0] && !ctl_wr)
      |=> !ctl_rdata[5]);

  p_pulse_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $past(vec_ack));

  p_ret_hi_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_svc_hi) |=> !in_svc_hi);

  p_ret_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !in_svc_hi && !vec_ack) |=> !in_svc_lo);
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glob_en   (glob_en),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .vec_ack   (vec_ack),
  .reti      (reti),
  .ctl_wr    (ctl_wr),
  .tmr_ovf   (tmr_ovf),
  .lvl_rdata (lvl_rdata),
  .ctl_rdata (ctl_rdata),
  .in_svc_hi (in_svc_hi),
  .in_svc_lo (in_svc_lo),
  .clr_pulse (clr_pulse)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lvl_wr, ctl_wr;
  logic [7:0] lvl_wdata, ctl_wdata, lvl_rdata, ctl_rdata;
  logic [1:0] ext_n, tmr_ovf;
  logic       ser_rx, ser_tx, glob_en, vec_ack, reti;
  logic [4:0] src_en;
  logic       irq_req, clr_pulse;
  logic [2:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .lvl_rdata(lvl_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .src_en(src_en), .glob_en(glob_en), .vec_ack(vec_ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .clr_pulse(clr_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    lvl_wr = 0; ctl_wr = 0; lvl_wdata = 0; ctl_wdata = 0;
    ext_n = 2'b11; tmr_ovf = 0; ser_rx = 0; ser_tx = 0;
    src_en = 5'h1f; glob_en = 1; vec_ack = 0; reti = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wr_lvl(input logic [7:0] v);
    lvl_wr = 1; lvl_wdata = v; step(1); lvl_wr = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; step(1); ctl_wr = 0;
  endtask

  task automatic pulse_tmr(input logic [1:0] m);
    tmr_ovf = m; step(1); tmr_ovf = 0;
  endtask

  task automatic ack;
    vec_ack = 1; step(1); vec_ack = 0;
  endtask

  task automatic ret;
    reti = 1; step(1); reti = 0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 level reg reset", lvl_rdata, 0);
    chk("R2 control reg reset", ctl_rdata, 0);
    chk("R10 no request after reset", irq_req, 0);
    chk("R9 no pulse after reset", clr_pulse, 0);
  endtask

  task automatic t_regs;
    do_reset();
    wr_lvl(8'hFF);
    chk("R1 reserved bits read 0", lvl_rdata, 8'h1F);
    wr_ctl(8'hFF);
    chk("R2 control bits 4,6 read 0", ctl_rdata, 8'hAF);
  endtask

  task automatic t_tie;
    do_reset();
    ser_rx = 1;
    pulse_tmr(2'b11);
    chk("R5 timer flags set", ctl_rdata & 8'hA0, 8'hA0);
    chk("R7 tie req", irq_req, 1);
    chk("R7 tie timer0 first", irq_vec, 1);
    ack();
    chk("R9 timer0 flag cleared", ctl_rdata & 8'hA0, 8'h80);
    chk("R9 clear pulse", clr_pulse, 1);
    chk("R10 low blocks low", irq_req, 0);
    step(1);
    chk("R9 pulse one cycle", clr_pulse, 0);
    ret();
    chk("R7 timer1 next", irq_vec, 3);
    chk("R11 low cleared req", irq_req, 1);
    ack(); ret();
    chk("R7 serial last", irq_vec, 4);
    ack();
    chk("R6 no pulse for serial", clr_pulse, 0);
    ret();
    ser_rx = 0; ser_tx = 1; step(1);
    chk("R6 tx requests", irq_req, 1);
    chk("R6 tx vector", irq_vec, 4);
  endtask

  task automatic t_prio;
    do_reset();
    wr_lvl(8'h10);
    ser_rx = 1;
    ctl_wr = 1; ctl_wdata = 8'h00; step(1); ctl_wr = 0;
    ext_n[0] = 0; step(3);
    pulse_tmr(2'b01);
    chk("R8 high serial beats low", irq_vec, 4);
  endtask

  task automatic t_edge;
    do_reset();
    wr_ctl(8'h01);
    ext_n[0] = 0; step(4);
    chk("R3 edge flag set", ctl_rdata[1], 1);
    chk("R3 edge vector", irq_vec, 0);
    ext_n[0] = 1; step(3);
    chk("R3 flag held after pin high", ctl_rdata[1], 1);
    ack();
    chk("R9 edge flag cleared", ctl_rdata[1], 0);
    chk("R9 edge clear pulse", clr_pulse, 1);
    ret();
    ext_n[0] = 0; step(4);
    ack(); ret(); step(3);
    chk("R3 held low no refire", irq_req, 0);
    ext_n[0] = 1;
  endtask

  task automatic t_level;
    do_reset();
    ext_n[1] = 0; step(3);
    chk("R4 level request", irq_req, 1);
    chk("R4 level vector", irq_vec, 2);
    chk("R4 no flag latched", ctl_rdata[3], 0);
    ack();
    step(0);
    chk("R9 level no pulse", clr_pulse, 0);
    ret();
    chk("R4 still requests while low", irq_req, 1);
    ext_n[1] = 1; step(3);
    chk("R4 request drops", irq_req, 0);
  endtask

  task automatic t_nest;
    do_reset();
    wr_lvl(8'h08);
    pulse_tmr(2'b01);
    chk("R10 low vector", irq_vec, 1);
    ack();
    chk("R10 low in service", irq_req, 0);
    pulse_tmr(2'b10);
    chk("R10 high preempts", irq_req, 1);
    chk("R10 high vector", irq_vec, 3);
    ack();
    pulse_tmr(2'b01);
    chk("R10 high blocks all", irq_req, 0);
    ret();
    chk("R11 high cleared first", irq_req, 0);
    ret();
    chk("R11 low cleared second", irq_req, 1);
    chk("R11 pending vector", irq_vec, 1);
  endtask

  task automatic t_mask;
    do_reset();
    pulse_tmr(2'b01);
    glob_en = 0; step(1);
    chk("R12 global mask", irq_req, 0);
    ack();
    chk("R12 ignored ack keeps flag", ctl_rdata[5], 1);
    chk("R12 ignored ack no pulse", clr_pulse, 0);
    glob_en = 1; step(1);
    chk("R12 unmasked", irq_vec, 1);
    src_en[1] = 0; step(1);
    chk("R12 source mask", irq_req, 0);
    chk("R12 flag kept", ctl_rdata[5], 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_tie();
    t_prio();
    t_edge();
    t_level();
    t_nest();
    t_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule